// File: doc/BRIEF.md
# Multi-Port Memory Unit Controller

This block fronts a single storage unit that several requesters share. Every cycle it looks at the pending requests. It accepts one of them by position, and it lets a held reservation and per-request urgency flags override that order. It then runs a short fixed sequence for the accepted request: capture and check, storage access, reply. Each request carries a word address with its own parity bit, 32 data bits with four byte parity bits, a direction flag and a 2-bit key.

The controller checks parity on the incoming address and on the incoming data. It keeps a per-byte parity nibble beside every stored word and checks that nibble again when the word is read. Before any store, it compares the request key against a small table that holds one lock per 512-word page. The requester gets back 32 data bits, which never include the parity nibble, and a 4-bit status word.

Port count is a parameter (2, 4 or 6). The address width is also a parameter: 14 or 15 bits for a full 16K/32K unit, and 11 bits by default so that the default array stays small.

Top module: `mem_unit_arb`

## Requirements
- R1: After reset, `gnt` is all zero, `done` is 0, and both `rdata` and `status` are zero.
- R2: When the unit is idle and requests are pending, the winner is chosen in this order. First, the port named by `rsv_port`, if `rsv_en` is 1 and that port requests. Otherwise, the lowest-numbered requesting port with `hipri` set. Otherwise, the lowest-numbered requesting port.
- R3: `gnt` is one-hot or zero. It appears on the cycle after the request is accepted. It stays on the winner for as long as that port keeps `req` high, even after the reply. Only after `req` drops and `gnt` has returned to zero for one cycle can another port be granted.
- R4: `done` is a one-cycle pulse. It rises two cycles after `gnt` first shows the winner. `rdata` and `status` are valid while `done` is high and hold until the next reply.
- R5: A write stores the 32 data bits. A later read of the same address returns them on `rdata`, with no parity bits mixed in.
- R6: Byte parity is odd. Bit i of a parity nibble covers data bits 8i+7..8i. The address parity bit makes the total count of ones across address plus parity odd.
- R7: Status bit 0 reports an address parity error. In that case there is no storage access: a write leaves the location unchanged, and a read returns `rdata` = 0.
- R8: Status bit 1 reports a data parity error on a write. The word is still stored, together with the parity nibble as received. A later read of that word then reports status bit 2 (storage parity error), while `rdata` still returns the data bits.
- R9: The lock table holds one 2-bit lock per 512-word page and is loaded through `lock_we`/`lock_page`/`lock_val`. Reset clears every lock to 00. A write goes ahead when the page lock is 00 or equals `wkey`. Otherwise the write is suppressed and status bit 3 (protection violation) is set.
- R10: Write replies return `rdata` = 0. Status bits 1 and 3 are only ever set by writes. Status bit 2 is only ever set by reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORTS | Request per port |
| wr | input | NPORTS | 1 = write, 0 = read, per port |
| hipri | input | NPORTS | Urgent flag per port |
| rsv_en | input | 1 | Unit is reserved |
| rsv_port | input | PW | Port holding the reservation |
| addr | input | NPORTS*AW | Word address, port p at [p*AW +: AW] |
| addr_par | input | NPORTS | Odd parity bit of each address |
| wdata | input | NPORTS*32 | Write data, port p at [p*32 +: 32] |
| wdata_par | input | NPORTS*4 | Byte parity nibble, port p at [p*4 +: 4] |
| wkey | input | NPORTS*2 | Write key, port p at [p*2 +: 2] |
| lock_we | input | 1 | Load one page lock |
| lock_page | input | AW-9 | Page index to load |
| lock_val | input | 2 | Lock value to load |
| gnt | output | NPORTS | One-hot grant |
| done | output | 1 | Reply pulse |
| rdata | output | 32 | Read data |
| status | output | 4 | {protection, storage parity, data parity, address parity} |

## Verification
If the sequencer state is wrong, it shows first on `gnt`. A grant that drops while its request is still high, or that moves to another port, is visible in the very next cycle. A `done` pulse that comes one cycle early or late breaks the fixed two-cycle spacing after the grant. If the stored parity nibble or the lock table is corrupted, nothing shows at write time. The fault appears only at the next read of that word, as a wrong status bit 2, or at the next write to that page, as a wrong status bit 3 together with unchanged read-back data. The bench therefore always pairs each store with a later read of the same address.

// File: rtl/mem_unit_arb.sv
module mem_unit_arb #(
  parameter int NPORTS  = 4,
  parameter int AW      = 11,
  parameter int PAGE_AW = 9,
  localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int PGW    = AW - PAGE_AW,
  localparam int DEPTH  = 1 << AW,
  localparam int NPAGE  = 1 << PGW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req,
  input  logic [NPORTS-1:0]    wr,
  input  logic [NPORTS-1:0]    hipri,
  input  logic                 rsv_en,
  input  logic [PW-1:0]        rsv_port,
  input  logic [NPORTS*AW-1:0] addr,
  input  logic [NPORTS-1:0]    addr_par,
  input  logic [NPORTS*32-1:0] wdata,
  input  logic [NPORTS*4-1:0]  wdata_par,
  input  logic [NPORTS*2-1:0]  wkey,
  input  logic                 lock_we,
  input  logic [PGW-1:0]       lock_page,
  input  logic [1:0]           lock_val,
  output logic [NPORTS-1:0]    gnt,
  output logic                 done,
  output logic [31:0]          rdata,
  output logic [3:0]           status
);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_RSP, S_HOLD} state_t;

  function automatic logic [3:0] odd_bytes(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^d[8*i +: 8];
    return p;
  endfunction

  state_t           st;
  logic [PW-1:0]    sel, win;
  logic             any_req, rsv_hit;
  logic [AW-1:0]    a_q;
  logic             ap_q, w_q, rd_ok_q;
  logic [31:0]      d_q;
  logic [3:0]       dp_q, flags_q;
  logic [1:0]       k_q;
  logic [35:0]      dout_q;
  logic [35:0]      mem [DEPTH];
  logic [1:0]       locks [NPAGE];

  assign any_req = |req;
  assign rsv_hit = rsv_en && (int'(rsv_port) < NPORTS) && req[rsv_port];

  always_comb begin
    win = '0;
    for (int i = NPORTS-1; i >= 0; i--) if (req[i]) win = PW'(i);
    for (int i = NPORTS-1; i >= 0; i--) if (req[i] && hipri[i]) win = PW'(i);
    if (rsv_hit) win = rsv_port;
  end

  assign gnt = (st != S_IDLE) ? (NPORTS'(1) << sel) : '0;

  logic       aerr, derr, prot, do_wr, serr;
  logic [1:0] lk;
  assign aerr  = ~(^{a_q, ap_q});
  assign derr  = w_q && (odd_bytes(d_q) != dp_q);
  assign lk    = locks[a_q[AW-1:PAGE_AW]];
  assign prot  = w_q && !aerr && (lk != 2'b00) && (k_q != lk);
  assign do_wr = w_q && !aerr && !prot;
  assign serr  = odd_bytes(dout_q[31:0]) != dout_q[35:32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sel     <= '0;
      a_q     <= '0;
      ap_q    <= 1'b1;
      w_q     <= 1'b0;
      d_q     <= '0;
      dp_q    <= '0;
      k_q     <= '0;
      flags_q <= '0;
      rd_ok_q <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      status  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (any_req) begin
          sel  <= win;
          a_q  <= addr[int'(win)*AW +: AW];
          ap_q <= addr_par[win];
          w_q  <= wr[win];
          d_q  <= wdata[int'(win)*32 +: 32];
          dp_q <= wdata_par[int'(win)*4 +: 4];
          k_q  <= wkey[int'(win)*2 +: 2];
          st   <= S_ACC;
        end
        S_ACC: begin
          flags_q <= {prot, 1'b0, derr, aerr};
          rd_ok_q <= !w_q && !aerr;
          st      <= S_RSP;
        end
        S_RSP: begin
          done   <= 1'b1;
          rdata  <= rd_ok_q ? dout_q[31:0] : '0;
          status <= {flags_q[3], rd_ok_q && serr, flags_q[1:0]};
          st     <= S_HOLD;
        end
        default: if (!req[sel]) st <= S_IDLE;
      endcase
    end
  end

  // stored nibble is the received one, so a bad incoming byte stays poisoned
  always_ff @(posedge clk) begin
    if (st == S_ACC && do_wr) mem[a_q] <= {dp_q, d_q};
    dout_q <= mem[a_q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) locks[i] <= 2'b00;
    end else if (lock_we) begin
      locks[lock_page] <= lock_val;
    end
  end

endmodule

// File: rtl/mem_unit_arb_chk.sv
module mem_unit_arb_chk #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] req,
  input logic [NPORTS-1:0] gnt,
  input logic              rsv_en,
  input logic [PW-1:0]     rsv_port,
  input logic              done,
  input logic [31:0]       rdata,
  input logic [3:0]        status
);

  logic [NPORTS-1:0] rsv_vec;
  always_comb begin
    rsv_vec = '0;
    if (rsv_en && (int'(rsv_port) < NPORTS) && req[rsv_port])
      rsv_vec = NPORTS'(1) << rsv_port;
  end

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_gnt_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req)) |=> (gnt == $past(gnt)));

  p_gnt_to_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt) |-> (|(gnt & $past(req))));

  p_rsv_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|gnt) && (|$past(rsv_vec))) |-> (gnt == $past(rsv_vec)));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt) |-> ##2 done);

  p_addr_err_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[0]) |-> (rdata == 32'd0 && !status[2]));

  p_status_kinds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(status[2] && (status[1] || status[3])));

endmodule

bind mem_unit_arb mem_unit_arb_chk #(.NPORTS(NPORTS), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .rsv_en(rsv_en),
  .rsv_port(rsv_port), .done(done), .rdata(rdata), .status(status)
);

// File: tb/mem_unit_arb_tb_top.sv
module mem_unit_arb_tb_top;
  localparam int NP = 4;
  localparam int AW = 11;
  localparam int PW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   req = '0, wr = '0, hipri = '0, addr_par = '0;
  logic            rsv_en = 1'b0;
  logic [PW-1:0]   rsv_port = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*32-1:0] wdata = '0;
  logic [NP*4-1:0]  wdata_par = '0;
  logic [NP*2-1:0]  wkey = '0;
  logic            lock_we = 1'b0;
  logic [AW-10:0]  lock_page = '0;
  logic [1:0]      lock_val = '0;
  logic [NP-1:0]   gnt;
  logic            done;
  logic [31:0]     rdata;
  logic [3:0]      status;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mem_unit_arb #(.NPORTS(NP), .AW(AW)) dut_i (
    .clk, .rst_n, .req, .wr, .hipri, .rsv_en, .rsv_port, .addr, .addr_par,
    .wdata, .wdata_par, .wkey, .lock_we, .lock_page, .lock_val,
    .gnt, .done, .rdata, .status
  );

  function automatic logic [3:0] bpar(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^d[8*i +: 8];
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_port(input int p, input bit w, input int a, input logic [31:0] d,
                          input logic [1:0] k, input bit bad_ap, input logic [3:0] flip);
    wr[p] = w;
    addr[p*AW +: AW] = AW'(a);
    addr_par[p] = (~^AW'(a)) ^ bad_ap;
    wdata[p*32 +: 32] = d;
    wdata_par[p*4 +: 4] = bpar(d) ^ flip;
    wkey[p*2 +: 2] = k;
  endtask

  task automatic run_txn(input string tag, input int p, input bit w, input int a,
                         input logic [31:0] d, input logic [1:0] k, input bit bad_ap,
                         input logic [3:0] flip, output logic [31:0] rd, output logic [3:0] st);
    @(negedge clk);
    set_port(p, w, a, d, k, bad_ap, flip);
    req[p] = 1'b1;
    @(negedge clk);
    check({tag, " R3 grant"}, 32'(gnt), 32'(1 << p));
    check({tag, " R4 no early done"}, 32'(done), 0);
    @(negedge clk);
    check({tag, " R4 no done at +1"}, 32'(done), 0);
    @(negedge clk);
    check({tag, " R4 done at +2"}, 32'(done), 1);
    rd = rdata;
    st = status;
    req[p] = 1'b0;
    @(negedge clk);
    check({tag, " R3 grant released"}, 32'(gnt), 0);
    check({tag, " R4 done pulse"}, 32'(done), 0);
  endtask

  task automatic load_lock(input int page, input logic [1:0] v);
    @(negedge clk);
    lock_we = 1'b1; lock_page = (AW-9)'(page); lock_val = v;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 gnt", 32'(gnt), 0);
    check("R1 done", 32'(done), 0);
    check("R1 rdata", rdata, 0);
    check("R1 status", 32'(status), 0);
  endtask

  task automatic t_write_read;
    logic [31:0] rd; logic [3:0] st;
    run_txn("R5 wr", 1, 1, 3, 32'hA55A_0F0F, 2'b00, 0, 4'b0, rd, st);
    check("R10 write rdata zero", rd, 0);
    check("R5 write status", 32'(st), 0);
    run_txn("R5 rd", 3, 0, 3, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R5 read data", rd, 32'hA55A_0F0F);
    check("R5 read status", 32'(st), 0);
    run_txn("R5 wr2", 0, 1, 1000, 32'h8000_0001, 2'b11, 0, 4'b0, rd, st);
    run_txn("R5 rd2", 2, 0, 1000, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R5 read data top bit", rd, 32'h8000_0001);
  endtask

  task automatic arb_case(input string tag, input logic [NP-1:0] r, input logic [NP-1:0] h,
                          input bit ren, input int rp, input logic [NP-1:0] exp);
    @(negedge clk);
    for (int p = 0; p < NP; p++) set_port(p, 0, 3, 32'h0, 2'b00, 0, 4'b0);
    hipri = h; rsv_en = ren; rsv_port = PW'(rp);
    req = r;
    @(negedge clk);
    check({tag, " R2 winner"}, 32'(gnt), 32'(exp));
    repeat (2) @(negedge clk);
    check({tag, " R4 done"}, 32'(done), 1);
    req = '0; hipri = '0; rsv_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_priority;
    arb_case("pos", 4'b1010, 4'b0000, 0, 0, 4'b0010);
    arb_case("hipri", 4'b1101, 4'b1100, 0, 0, 4'b0100);
    arb_case("rsv", 4'b1001, 4'b0001, 1, 3, 4'b1000);
    arb_case("rsv idle", 4'b0101, 4'b0000, 1, 1, 4'b0001);
    arb_case("all", 4'b1111, 4'b0000, 0, 0, 4'b0001);
  endtask

  task automatic t_hold;
    @(negedge clk);
    set_port(2, 0, 3, 32'h0, 2'b00, 0, 4'b0);
    set_port(0, 0, 3, 32'h0, 2'b00, 0, 4'b0);
    req[2] = 1'b1;
    @(negedge clk);
    req[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 hold read data", rdata, 32'hA55A_0F0F);
    repeat (3) begin
      @(negedge clk);
      check("R3 grant kept while req high", 32'(gnt), 32'b0100);
    end
    req[2] = 1'b0;
    @(negedge clk);
    check("R3 gap cycle", 32'(gnt), 0);
    @(negedge clk);
    check("R3 next port granted", 32'(gnt), 32'b0001);
    repeat (2) @(negedge clk);
    check("R4 second done", 32'(done), 1);
    req = '0;
    @(negedge clk);
  endtask

  task automatic t_addr_parity;
    logic [31:0] rd; logic [3:0] st;
    run_txn("R7 bad wr", 1, 1, 3, 32'hDEAD_BEEF, 2'b00, 1, 4'b0, rd, st);
    check("R7 write status", 32'(st), 32'b0001);
    run_txn("R7 rd back", 1, 0, 3, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R7 location unchanged", rd, 32'hA55A_0F0F);
    run_txn("R7 bad rd", 1, 0, 3, 32'h0, 2'b00, 1, 4'b0, rd, st);
    check("R7 read data zero", rd, 0);
    check("R7 read status", 32'(st), 32'b0001);
  endtask

  task automatic t_data_parity;
    logic [31:0] rd; logic [3:0] st;
    run_txn("R8 bad data", 2, 1, 5, 32'h1234_5678, 2'b00, 0, 4'b0010, rd, st);
    check("R8 data parity status", 32'(st), 32'b0010);
    check("R6 R10 write rdata", rd, 0);
    run_txn("R8 poisoned rd", 0, 0, 5, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R8 data still returned", rd, 32'h1234_5678);
    check("R8 storage parity status", 32'(st), 32'b0100);
    run_txn("R6 clean wr", 2, 1, 5, 32'hFFFF_0000, 2'b00, 0, 4'b0, rd, st);
    run_txn("R6 clean rd", 0, 0, 5, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R6 clean status", 32'(st), 0);
    check("R6 clean data", rd, 32'hFFFF_0000);
  endtask

  task automatic t_lock;
    logic [31:0] rd; logic [3:0] st;
    load_lock(1, 2'b10);
    run_txn("R9 key match", 3, 1, 600, 32'h0000_00D0, 2'b10, 0, 4'b0, rd, st);
    check("R9 match status", 32'(st), 0);
    run_txn("R9 key wrong", 1, 1, 600, 32'h0000_00D1, 2'b01, 0, 4'b0, rd, st);
    check("R9 violation status", 32'(st), 32'b1000);
    run_txn("R9 rd", 0, 0, 600, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R9 write suppressed", rd, 32'h0000_00D0);
    run_txn("R9 open page", 1, 1, 7, 32'h0BAD_F00D, 2'b11, 0, 4'b0, rd, st);
    check("R9 lock 00 any key", 32'(st), 0);
    run_txn("R9 open rd", 2, 0, 7, 32'h0, 2'b00, 0, 4'b0, rd, st);
    check("R9 open data", rd, 32'h0BAD_F00D);
    run_txn("R9 both", 0, 1, 700, 32'h5, 2'b11, 0, 4'b1000, rd, st);
    check("R9 R10 violation plus data error", 32'(st), 32'b1010);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_priority();
        t_hold();
        t_addr_parity();
        t_data_parity();
        t_lock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule